// File: doc/BRIEF.md
# External Video Sync Slave Conditioner

This block sits at the timing input of a standard-definition video encoder. It accepts a horizontal sync, a vertical sync and a field identifier from an external source. From them it produces clean, active-high sync pulses and one resolved field identifier. A small configuration register picks the timing source. In master mode the block forwards the encoder's own internally generated horizontal sync, vertical sync and field. In slave mode it forwards the conditioned external signals.

In slave mode, each external input has its own inversion control. The field identifier can be derived in four ways:
- latched at each vertical sync leading edge;
- taken directly from the external field input;
- taken from the vertical sync level;
- inferred from where the vertical sync leading edge falls within the current line.

For the last method, a line-position counter restarts at every horizontal sync leading edge and remembers the length of the previous line. All inputs are assumed to be synchronous to the pixel clock already. Every output is registered, so each output follows its inputs by exactly one clock.

Top module: `vsync_slave_cond`

## Requirements
- R1: With configuration bit 0 (slave select) at 0, hsync_o, vsync_o and field_o equal int_hsync, int_vsync and int_field as they stood one clock earlier.
- R2: With slave select at 1, hsync_o equals ext_hsync XOR configuration bit 1 (0 = active high, 1 = active low) from one clock earlier.
- R3: With slave select at 1, vsync_o equals ext_vsync XOR configuration bit 2 (0 = active high, 1 = active low) from one clock earlier.
- R4: The conditioned field equals ext_field XOR configuration bit 3 (1 = invert). This is the value that the field modes consume.
- R5: Field mode 0 (bits 5:4 = 0): at each rising edge of the conditioned vertical sync, field_o takes the conditioned field, appearing together with the vsync_o rise. Between edges it holds.
- R6: Field mode 1: field_o equals the conditioned field from one clock earlier, with no latching.
- R7: Field mode 2: field_o equals the conditioned vertical sync from one clock earlier.
- R8: Field mode 3: at each rising edge of the conditioned vertical sync, field_o becomes 1 when twice the position of that edge in the line (in clocks since the latest horizontal sync rising edge, 0 on that edge) is at least the previous line's length, and becomes 0 otherwise. Between edges it holds. Before the first measured line, the length is 0.
- R9: A write stores bits 5:0 (slave, horizontal polarity, vertical polarity, field inversion, field mode) and is visible on reg_rdata from the next clock. reg_rdata bits above 5 read 0, and all fields reset to 0.
- R10: In master mode the polarity, inversion and field-mode fields have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Configuration write strobe |
| reg_wdata | input | 6 | Configuration write data |
| reg_rdata | output | 32 | Configuration read-back, upper bits zero |
| int_hsync | input | 1 | Internal master horizontal sync |
| int_vsync | input | 1 | Internal master vertical sync |
| int_field | input | 1 | Internal master field identifier |
| ext_hsync | input | 1 | External horizontal sync |
| ext_vsync | input | 1 | External vertical sync |
| ext_field | input | 1 | External field identifier |
| hsync_o | output | 1 | Active-high horizontal sync |
| vsync_o | output | 1 | Active-high vertical sync |
| field_o | output | 1 | Resolved field identifier |

## Verification
The assertions assume that every input, including the register write port, changes only between clock edges and has a defined value after reset. They also assume that the field-mode hold check is meaningful only when the configuration has been steady for two clocks. The stimulus drives all inputs on the falling clock edge and writes each of the 64 configurations in turn. For each configuration it plays periodic lines and frames with the vertical sync phase moved between frames, or fully random pulses. This places vertical sync edges in both halves of a line and also on a horizontal sync edge.

// File: rtl/vsc_pkg.sv
// Shared types for the sync slave conditioner.
// Assumes the configuration word is packed with slave select in bit 0.
package vsc_pkg;

    localparam int CFG_W = 6;

    typedef enum logic [1:0] {
        FM_VLATCH = 2'd0,
        FM_DIRECT = 2'd1,
        FM_VLEVEL = 2'd2,
        FM_PHASE  = 2'd3
    } fmode_e;

    typedef struct packed {
        fmode_e fmode;   // bits 5:4
        logic   finv;    // bit 3
        logic   vpol;    // bit 2
        logic   hpol;    // bit 1
        logic   slave;   // bit 0
    } vsc_cfg_t;

endpackage

// File: rtl/vsc_cfg_reg.sv
// Configuration register: stores the six control bits and returns them
// zero-extended on the read port. Assumes DATA_W exceeds the field width.
module vsc_cfg_reg
    import vsc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [CFG_W-1:0]     wdata,
    output vsc_cfg_t             cfg,
    output logic [DATA_W-1:0]    rdata
);
    localparam int PAD_W = DATA_W - CFG_W;

    // Capture a new configuration on each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr) begin
            cfg <= vsc_cfg_t'(wdata);
        end
    end

    // Read-back with the unused upper bits tied low.
    always_comb begin
        rdata = {{PAD_W{1'b0}}, cfg};
    end
endmodule

// File: rtl/vsc_sync_edge.sv
// Polarity normalizer with a one-clock delayed copy for rising-edge detect.
// Assumes the raw input is already synchronous to clk.
module vsc_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic inv,
    output logic lvl,
    output logic rise
);
    logic lvl_d;

    // Apply the configured polarity.
    always_comb begin
        lvl  = raw ^ inv;
        rise = lvl & ~lvl_d;
    end

    // Keep last cycle's normalized level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_d <= 1'b0;
        end else begin
            lvl_d <= lvl;
        end
    end
endmodule

// File: rtl/vsc_field_resolve.sv
// Field identifier resolver: picks among a latched field, the direct field,
// the vertical sync level, or a field inferred from the vertical sync edge
// position within the line. Assumes normalized, edge-detected inputs.
module vsc_field_resolve
    import vsc_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic   clk,
    input  logic   rst_n,
    input  fmode_e mode,
    input  logic   h_rise,
    input  logic   v_rise,
    input  logic   v_lvl,
    input  logic   f_lvl,
    output logic   fid_next
);
    localparam logic [CNT_W-1:0] POS_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] pos_q;
    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] cur_pos;
    logic             late_half;
    logic             lat_q;
    logic             ph_q;

    // Position in the current line; zero on a horizontal leading edge.
    always_comb begin
        cur_pos   = h_rise ? '0 : pos_q;
        late_half = ({cur_pos, 1'b0} >= {1'b0, len_q});
    end

    // Line position counter and previous line length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            len_q <= '0;
        end else begin
            pos_q <= (cur_pos == POS_MAX) ? POS_MAX : cur_pos + CNT_W'(1);
            if (h_rise) begin
                len_q <= pos_q;
            end
        end
    end

    // Field holders updated at each vertical leading edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= 1'b0;
            ph_q  <= 1'b0;
        end else if (v_rise) begin
            lat_q <= f_lvl;
            ph_q  <= late_half;
        end
    end

    // Mode selection of the next field value.
    always_comb begin
        case (mode)
            FM_VLATCH: fid_next = v_rise ? f_lvl : lat_q;
            FM_DIRECT: fid_next = f_lvl;
            FM_VLEVEL: fid_next = v_lvl;
            default:   fid_next = v_rise ? late_half : ph_q;
        endcase
    end
endmodule

// File: rtl/vsync_slave_cond.sv
// Top of the sync slave conditioner: selects internal master timing or
// conditioned external sync and registers the three outputs.
// Assumes all inputs are synchronous to clk.
module vsync_slave_cond
    import vsc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [CFG_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              int_hsync,
    input  logic              int_vsync,
    input  logic              int_field,
    input  logic              ext_hsync,
    input  logic              ext_vsync,
    input  logic              ext_field,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              field_o
);
    localparam int NSYNC = 2;   // 0 = horizontal, 1 = vertical

    vsc_cfg_t         cfg;
    logic [NSYNC-1:0] s_raw;
    logic [NSYNC-1:0] s_inv;
    logic [NSYNC-1:0] s_lvl;
    logic [NSYNC-1:0] s_rise;
    logic             f_lvl;
    logic             fid_next;

    vsc_cfg_reg #(.DATA_W(DATA_W)) cfg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .cfg   (cfg),
        .rdata (reg_rdata)
    );

    // Route the sync inputs and polarity bits to the normalizers.
    always_comb begin
        s_raw = {ext_vsync, ext_hsync};
        s_inv = {cfg.vpol, cfg.hpol};
        f_lvl = ext_field ^ cfg.finv;
    end

    for (genvar g = 0; g < NSYNC; g++) begin : g_sync
        vsc_sync_edge edge_i (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (s_raw[g]),
            .inv   (s_inv[g]),
            .lvl   (s_lvl[g]),
            .rise  (s_rise[g])
        );
    end

    vsc_field_resolve #(.CNT_W(CNT_W)) fid_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (cfg.fmode),
        .h_rise   (s_rise[0]),
        .v_rise   (s_rise[1]),
        .v_lvl    (s_lvl[1]),
        .f_lvl    (f_lvl),
        .fid_next (fid_next)
    );

    // Output registers with master/slave source select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync_o <= 1'b0;
            vsync_o <= 1'b0;
            field_o <= 1'b0;
        end else if (cfg.slave) begin
            hsync_o <= s_lvl[0];
            vsync_o <= s_lvl[1];
            field_o <= fid_next;
        end else begin
            hsync_o <= int_hsync;
            vsync_o <= int_vsync;
            field_o <= int_field;
        end
    end
endmodule

// File: rtl/vsc_checker.sv
// Temporal checks on the conditioner's ports, bound to the top module.
// Assumes inputs change only between clock edges.
module vsc_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [5:0]        reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              int_hsync,
    input logic              int_vsync,
    input logic              int_field,
    input logic              ext_hsync,
    input logic              ext_vsync,
    input logic              ext_field,
    input logic              hsync_o,
    input logic              vsync_o,
    input logic              field_o
);
    logic [1:0] hist;

    // Count clocks since reset so $past stays within valid history.
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= 2'd0;
        else if (hist != 2'd3) hist <= hist + 2'd1;
    end

    a_r1_master_hs: assert property (@(posedge clk) disable iff (!rst_n)
        (hist >= 2'd1 && !$past(reg_rdata[0])) |-> hsync_o == $past(int_hsync));
    a_r1_master_vs: assert property (@(posedge clk) disable iff (!rst_n)
        (hist >= 2'd1 && !$past(reg_rdata[0])) |-> vsync_o == $past(int_vsync));
    a_r10_master_fid: assert property (@(posedge clk) disable iff (!rst_n)
        (hist >= 2'd1 && !$past(reg_rdata[0])) |-> field_o == $past(int_field));
    a_r2_slave_hs: assert property (@(posedge clk) disable iff (!rst_n)
        (hist >= 2'd1 && $past(reg_rdata[0])) |-> hsync_o == $past(ext_hsync ^ reg_rdata[1]));
    a_r3_slave_vs: assert property (@(posedge clk) disable iff (!rst_n)
        (hist >= 2'd1 && $past(reg_rdata[0])) |-> vsync_o == $past(ext_vsync ^ reg_rdata[2]));
    a_r6_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (hist >= 2'd1 && $past(reg_rdata[0]) && $past(reg_rdata[5:4]) == 2'd1)
        |-> field_o == $past(ext_field ^ reg_rdata[3]));
    a_r7_vlevel: assert property (@(posedge clk) disable iff (!rst_n)
        (hist >= 2'd1 && $past(reg_rdata[0]) && $past(reg_rdata[5:4]) == 2'd2)
        |-> field_o == $past(ext_vsync ^ reg_rdata[2]));
    a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hist >= 2'd2 && $past(reg_rdata[5:0]) == $past(reg_rdata[5:0], 2)
         && $past(reg_rdata[0]) && $past(reg_rdata[5:4]) == 2'd0 && !$rose(vsync_o))
        |-> $stable(field_o));
    a_r9_write: assert property (@(posedge clk) disable iff (!rst_n)
        (hist >= 2'd1 && $past(reg_wr)) |-> reg_rdata[5:0] == $past(reg_wdata));
endmodule

bind vsync_slave_cond vsc_checker #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .int_hsync (int_hsync),
    .int_vsync (int_vsync),
    .int_field (int_field),
    .ext_hsync (ext_hsync),
    .ext_vsync (ext_vsync),
    .ext_field (ext_field),
    .hsync_o   (hsync_o),
    .vsync_o   (vsync_o),
    .field_o   (field_o)
);

// File: tb/vsync_slave_cond_tb.sv
module vsync_slave_cond_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        int_hsync = 1'b0, int_vsync = 1'b0, int_field = 1'b0;
    logic        ext_hsync = 1'b0, ext_vsync = 1'b0, ext_field = 1'b0;
    logic        hsync_o, vsync_o, field_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // behavioural reference state
    int    m_cfg = 0;
    bit    m_hd = 0, m_vd = 0, m_lat = 0, m_ph = 0;
    int    m_pos = 0, m_len = 0;
    bit    e_h = 0, e_v = 0, e_f = 0;
    string t_h = "R1", t_v = "R1", t_f = "R1";

    always #2 clk = ~clk;

    vsync_slave_cond dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .int_hsync(int_hsync), .int_vsync(int_vsync),
        .int_field(int_field), .ext_hsync(ext_hsync), .ext_vsync(ext_vsync),
        .ext_field(ext_field), .hsync_o(hsync_o), .vsync_o(vsync_o), .field_o(field_o)
    );

    task automatic check(input int act, input int exp, input string tag, input string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model: one clock of the block, from the requirements.
    task automatic model_step();
        bit slave, nh, nv, nf, hr, vr, late, fid;
        int cur, mode;
        slave = m_cfg[0];
        mode  = (m_cfg >> 4) & 3;
        nh = ext_hsync ^ m_cfg[1];              // R2
        nv = ext_vsync ^ m_cfg[2];              // R3
        nf = ext_field ^ m_cfg[3];              // R4
        hr = nh && !m_hd;
        vr = nv && !m_vd;
        cur  = hr ? 0 : m_pos;
        late = (2 * cur >= m_len);              // R8
        case (mode)
            0: fid = vr ? nf : m_lat;           // R5
            1: fid = nf;                        // R6
            2: fid = nv;                        // R7
            default: fid = vr ? late : m_ph;    // R8
        endcase
        if (slave) begin
            e_h = nh; e_v = nv; e_f = fid;
            t_h = "R2"; t_v = "R3";
            case (mode)
                0: t_f = "R5";
                1: t_f = m_cfg[3] ? "R4" : "R6";
                2: t_f = "R7";
                default: t_f = "R8";
            endcase
        end else begin
            e_h = int_hsync; e_v = int_vsync; e_f = int_field;
            t_h = (m_cfg != 0) ? "R10" : "R1";
            t_v = t_h; t_f = t_h;
        end
        if (vr) begin m_lat = nf; m_ph = late; end
        if (hr) m_len = m_pos;
        m_pos = (cur >= 4095) ? 4095 : cur + 1;
        m_hd = nh; m_vd = nv;
        if (reg_wr) m_cfg = int'(reg_wdata);    // R9
    endtask

    task automatic model_reset();
        m_cfg = 0; m_hd = 0; m_vd = 0; m_lat = 0; m_ph = 0;
        m_pos = 0; m_len = 0; e_h = 0; e_v = 0; e_f = 0;
        t_h = "R1"; t_v = "R1"; t_f = "R1";
    endtask

    task automatic compare_all();
        check(int'(hsync_o), int'(e_h), t_h, "hsync_o");
        check(int'(vsync_o), int'(e_v), t_v, "vsync_o");
        check(int'(field_o), int'(e_f), t_f, "field_o");
        check(int'(reg_rdata), m_cfg, "R9", "reg_rdata");
    endtask

    initial begin
        int L, frame_len, off, cyc;
        bit hs_a, vs_a, fd_a;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            model_reset();
        end
        @(negedge clk);
        compare_all();          // reset state, R9
        rst_n = 1'b1;
        for (int c = 0; c < 64; c++) begin
            @(negedge clk);
            compare_all();
            reg_wr = 1'b1;
            reg_wdata = 6'(c);
            model_step();
            L = 20 + (c % 7) * 3;
            frame_len = L * 6;
            for (int k = 0; k < 300; k++) begin
                @(negedge clk);
                compare_all();
                reg_wr = 1'b0;
                cyc = k;
                off = ((cyc / frame_len) % 2 == 1) ? (L / 2 + 3) : 0;
                hs_a = (cyc % L) < 4;
                vs_a = ((cyc + frame_len - off) % frame_len) < 2 * L;
                fd_a = ((cyc / frame_len) % 2) == 1;
                if (c % 4 == 3) begin
                    hs_a = $urandom_range(0, 7) == 0;
                    vs_a = $urandom_range(0, 5) == 0;
                    fd_a = $urandom_range(0, 1) == 1;
                end
                ext_hsync = hs_a ^ c[1];
                ext_vsync = vs_a ^ c[2];
                ext_field = fd_a;
                int_hsync = $urandom_range(0, 1) == 1;
                int_vsync = $urandom_range(0, 1) == 1;
                int_field = $urandom_range(0, 1) == 1;
                model_step();
            end
        end
        @(negedge clk);
        compare_all();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule